// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block steers the two ALU operand multiplexers of an in-order, five-stage integer pipeline and decides when the front end must pause. Each cycle it looks at the source register numbers of the instruction now in execute and of the instruction now in decode. It compares them with the destination, write-enable and load flag held in the ID/EX, EX/MEM and MEM/WB pipeline registers. From that comparison it picks, for each operand separately, one of three values: the register-file read, the result waiting in EX/MEM, or the result waiting in MEM/WB.

An ALU result can be used by the very next instruction with no lost cycle, because it is already in EX/MEM. A loaded value only exists once the memory stage has finished. So a consumer that sits directly behind a load is held in decode for exactly one cycle, and a no-op is sent into execute in its place. On the following cycle the load has reached MEM/WB and the consumer picks the value up through that bypass. Writes happen in program order at the end of the pipeline, so the block needs no logic for write-after-read or write-after-write ordering. The block is purely combinational and drops in between the pipeline registers and the operand multiplexers.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: When no valid producer in EX/MEM or MEM/WB writes an execute-stage source register, that operand's select is 2'b00 (register file).
- R2: When the EX/MEM producer writes an execute-stage source register, that operand's select is 2'b10, and an ALU producer this close causes no stall.
- R3: When only the MEM/WB producer writes an execute-stage source register, that operand's select is 2'b01.
- R4: When both EX/MEM and MEM/WB write the same source register, the select is 2'b10 (the newer value wins).
- R5: A producer with write-enable low, or with destination register 0, never causes a bypass select or a stall.
- R6: When ID/EX holds a load with write-enable high, a nonzero destination, and a destination equal to either decode-stage source, stall, the IF/ID hold and the ID/EX bubble are all 1.
- R7: When ID/EX holds a non-load producer whose destination matches a decode-stage source, there is no stall.
- R8: The stall, IF/ID hold and ID/EX bubble outputs are always equal.
- R9: In a pipeline that advances under the block's control, a load-use pair costs exactly one stall cycle, and the consumer then takes the loaded operand through the MEM/WB select (2'b01).
- R10: The two operand selects are worked out independently, so operand A and operand B may carry different codes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| idex_dst | input | 5 | Destination held in ID/EX |
| idex_wen | input | 1 | Register write-enable held in ID/EX |
| idex_load | input | 1 | ID/EX instruction is a load |
| exmem_dst | input | 5 | Destination held in EX/MEM |
| exmem_wen | input | 1 | Register write-enable held in EX/MEM |
| memwb_dst | input | 5 | Destination held in MEM/WB |
| memwb_wen | input | 1 | Register write-enable held in MEM/WB |
| opa_sel | output | 2 | Operand A select: 00 register file, 10 EX/MEM, 01 MEM/WB |
| opb_sel | output | 2 | Operand B select, same encoding |
| stall | output | 1 | Load-use interlock active; PC must hold |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged |
| idex_bubble | output | 1 | Clear the control bits latched into ID/EX |

## Verification
The hardest case to reach is the handover after an interlock. The stalled consumer must get its operand from MEM/WB one cycle later, and that only happens if the surrounding pipeline really holds decode, injects the bubble and shifts the load onward. So the bench carries a small behavioural pipeline that obeys the block's own stall output, and feeds it instruction streams with load-use pairs, back-to-back ALU chains, writes to register 0 and disabled writes. A long phase of random stage contents, drawn from a tiny register range, then hits many double-match and mixed-operand cases.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

    // Width of a register index; 32 architectural registers by default
    parameter int REG_AW  = 5;
    // Number of ALU source operands
    parameter int NUM_SRC = 2;

    typedef logic [REG_AW-1:0] regidx_t;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMWB   = 2'b01,
        SEL_EXMEM   = 2'b10
    } opsel_e;

    // An in-flight instruction as seen from a pipeline register
    typedef struct packed {
        regidx_t dst;
        logic    wen;
        logic    is_load;
    } producer_t;

    // True when the producer will really update register r
    function automatic logic will_write(producer_t p, regidx_t r);
        return p.wen && (p.dst != '0) && (p.dst == r);
    endfunction

endpackage

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
    import fwd_hazard_pkg::*;
(
    input  regidx_t   src,
    input  producer_t near_p,
    input  producer_t far_p,
    output opsel_e    sel
);
    logic hit_near;
    logic hit_far;

    assign hit_near = will_write(near_p, src);
    assign hit_far  = will_write(far_p, src);

    // The nearer stage holds the younger producer, so it wins
    always_comb begin
        if (hit_near)     sel = SEL_EXMEM;
        else if (hit_far) sel = SEL_MEMWB;
        else              sel = SEL_REGFILE;
    end
endmodule

// File: rtl/fwd_loaduse_detect.sv
module fwd_loaduse_detect
    import fwd_hazard_pkg::*;
(
    input  regidx_t   id_src [NUM_SRC],
    input  producer_t ex_p,
    output logic      hazard
);
    logic [NUM_SRC-1:0] match;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_cmp
            assign match[g] = ex_p.is_load && will_write(ex_p, id_src[g]);
        end
    endgenerate

    assign hazard = |match;
endmodule

// File: rtl/fwd_interlock_drive.sv
module fwd_interlock_drive (
    input  logic hazard,
    output logic pc_freeze,
    output logic decode_keep,
    output logic exec_clear
);
    // One hazard flag fans out to every front-end control
    assign pc_freeze   = hazard;
    assign decode_keep = hazard;
    assign exec_clear  = hazard;
endmodule

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
    import fwd_hazard_pkg::*;
(
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic [REG_AW-1:0] idex_dst,
    input  logic              idex_wen,
    input  logic              idex_load,
    input  logic [REG_AW-1:0] exmem_dst,
    input  logic              exmem_wen,
    input  logic [REG_AW-1:0] memwb_dst,
    input  logic              memwb_wen,
    output logic [1:0]        opa_sel,
    output logic [1:0]        opb_sel,
    output logic              stall,
    output logic              ifid_hold,
    output logic              idex_bubble
);
    producer_t p_idex, p_exmem, p_memwb;
    regidx_t   ex_src [NUM_SRC];
    regidx_t   id_src [NUM_SRC];
    opsel_e    sel    [NUM_SRC];
    logic      lu_hazard;

    assign p_idex  = '{dst: idex_dst,  wen: idex_wen,  is_load: idex_load};
    // Stages past execute never stall a consumer, so their load flag is unused
    assign p_exmem = '{dst: exmem_dst, wen: exmem_wen, is_load: 1'b0};
    assign p_memwb = '{dst: memwb_dst, wen: memwb_wen, is_load: 1'b0};

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;
    assign id_src[0] = id_src_a;
    assign id_src[1] = id_src_b;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_opsel
            fwd_operand_select u_sel (
                .src    (ex_src[g]),
                .near_p (p_exmem),
                .far_p  (p_memwb),
                .sel    (sel[g])
            );
        end
    endgenerate

    assign opa_sel = sel[0];
    assign opb_sel = sel[1];

    fwd_loaduse_detect u_lud (
        .id_src (id_src),
        .ex_p   (p_idex),
        .hazard (lu_hazard)
    );

    fwd_interlock_drive u_ild (
        .hazard      (lu_hazard),
        .pc_freeze   (stall),
        .decode_keep (ifid_hold),
        .exec_clear  (idex_bubble)
    );
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk
    import fwd_hazard_pkg::*;
(
    input logic [REG_AW-1:0] ex_src_a,
    input logic [REG_AW-1:0] ex_src_b,
    input logic [REG_AW-1:0] id_src_a,
    input logic [REG_AW-1:0] id_src_b,
    input logic [REG_AW-1:0] idex_dst,
    input logic              idex_wen,
    input logic              idex_load,
    input logic [REG_AW-1:0] exmem_dst,
    input logic              exmem_wen,
    input logic [REG_AW-1:0] memwb_dst,
    input logic              memwb_wen,
    input logic [1:0]        opa_sel,
    input logic [1:0]        opb_sel,
    input logic              stall,
    input logic              ifid_hold,
    input logic              idex_bubble
);
    logic em_a, mw_a, em_b, mw_b, lu;

    always_comb begin
        em_a = exmem_wen && exmem_dst != 0 && exmem_dst == ex_src_a;
        mw_a = memwb_wen && memwb_dst != 0 && memwb_dst == ex_src_a;
        em_b = exmem_wen && exmem_dst != 0 && exmem_dst == ex_src_b;
        mw_b = memwb_wen && memwb_dst != 0 && memwb_dst == ex_src_b;
        lu   = idex_load && idex_wen && idex_dst != 0 &&
               (idex_dst == id_src_a || idex_dst == id_src_b);

        // R1: nothing matching leaves the register-file path chosen
        if (!em_a && !mw_a)
            assert_regfile_a_R1: assert (opa_sel == 2'b00);
        // R2 and R4: EX/MEM match always wins
        if (em_a)
            assert_exmem_a_R2: assert (opa_sel == 2'b10);
        if (em_b && mw_b)
            assert_exmem_pri_b_R4: assert (opb_sel == 2'b10);
        // R3: MEM/WB alone
        if (mw_b && !em_b)
            assert_memwb_b_R3: assert (opb_sel == 2'b01);
        // R5: disabled producers never bypass
        if (!exmem_wen && !memwb_wen)
            assert_nowrite_R5: assert (opa_sel == 2'b00 && opb_sel == 2'b00);
        // R6 and R7: stall exactly on a load-use match
        assert_loaduse_R6: assert (stall == lu);
        // R8: the three interlock controls agree
        assert_ctrl_agree_R8: assert (stall == ifid_hold && stall == idex_bubble);
    end
endmodule

bind fwd_hazard_ctrl fwd_hazard_chk u_chk (.*);

// File: tb/sim_fwd_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_fwd_hazard_ctrl;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] ex_src_a, ex_src_b, id_src_a, id_src_b;
    logic [4:0] idex_dst, exmem_dst, memwb_dst;
    logic       idex_wen, idex_load, exmem_wen, memwb_wen;
    logic [1:0] opa_sel, opb_sel;
    logic       stall, ifid_hold, idex_bubble;

    int checks = 0;
    int errors = 0;

    fwd_hazard_ctrl u0 (.*);

    typedef struct {
        int  dst, s1, s2;
        bit  wen, ld;
        bit  stalled;
    } ins_t;

    ins_t stg_id, stg_ex, stg_mem, stg_wb;
    ins_t prog[$];
    int   stall_run;

    function automatic ins_t nop();
        ins_t n;
        n.dst = 0; n.s1 = 0; n.s2 = 0; n.wen = 0; n.ld = 0; n.stalled = 0;
        return n;
    endfunction

    function automatic ins_t mk(int d, int a, int b, bit w, bit l);
        ins_t n;
        n.dst = d; n.s1 = a; n.s2 = b; n.wen = w; n.ld = l; n.stalled = 0;
        return n;
    endfunction

    // Reference: scan producers from youngest to oldest
    function automatic int ref_sel(int src);
        int dsts[2]; bit ens[2]; int codes[2];
        dsts[0] = exmem_dst; ens[0] = exmem_wen; codes[0] = 2;
        dsts[1] = memwb_dst; ens[1] = memwb_wen; codes[1] = 1;
        for (int k = 0; k < 2; k++)
            if (ens[k] && dsts[k] != 0 && dsts[k] == src) return codes[k];
        return 0;
    endfunction

    function automatic bit ref_stall();
        if (!idex_load || !idex_wen || idex_dst == 0) return 0;
        return (idex_dst == id_src_a) || (idex_dst == id_src_b);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int ea, eb; bit es;
        ea = ref_sel(ex_src_a);
        eb = ref_sel(ex_src_b);
        es = ref_stall();
        chk("R1/R2/R3/R4/R5 opA", opa_sel, ea);
        chk("R10 opB", opb_sel, eb);
        chk(idex_load ? "R6 stall" : "R7 stall", stall, es);
        chk("R8 hold", ifid_hold, stall);
        chk("R8 bubble", idex_bubble, stall);
    endtask

    task automatic drive_stages();
        ex_src_a  = stg_ex.s1[4:0];  ex_src_b = stg_ex.s2[4:0];
        id_src_a  = stg_id.s1[4:0];  id_src_b = stg_id.s2[4:0];
        idex_dst  = stg_ex.dst[4:0]; idex_wen = stg_ex.wen; idex_load = stg_ex.ld;
        exmem_dst = stg_mem.dst[4:0]; exmem_wen = stg_mem.wen;
        memwb_dst = stg_wb.dst[4:0];  memwb_wen = stg_wb.wen;
    endtask

    task automatic run_program();
        stg_id = nop(); stg_ex = nop(); stg_mem = nop(); stg_wb = nop();
        stall_run = 0;
        while (prog.size() != 0 || stg_id.wen || stg_ex.wen || stg_mem.wen) begin
            @(posedge clk); #1;
            drive_stages();
            @(negedge clk);
            compare_all();
            // R9: consumer that waited now reads the load via MEM/WB
            if (stg_ex.stalled && stg_wb.ld) begin
                if (stg_ex.s1 == stg_wb.dst) chk("R9 handover A", opa_sel, 1);
                if (stg_ex.s2 == stg_wb.dst) chk("R9 handover B", opb_sel, 1);
            end
            stall_run = stall ? stall_run + 1 : 0;
            if (stall_run > 1) chk("R9 single stall", stall_run, 1);
            stg_wb  = stg_mem;
            stg_mem = stg_ex;
            if (stall) begin
                stg_ex = nop();
                stg_id.stalled = 1;
            end else begin
                stg_ex = stg_id;
                stg_id = (prog.size() != 0) ? prog.pop_front() : nop();
            end
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nstall;
        ex_src_a = 0; ex_src_b = 0; id_src_a = 0; id_src_b = 0;
        idex_dst = 0; idex_wen = 0; idex_load = 0;
        exmem_dst = 0; exmem_wen = 0; memwb_dst = 0; memwb_wen = 0;
        @(negedge clk);
        // Idle pipeline state
        chk("R1 idle opA", opa_sel, 0);
        chk("R1 idle opB", opb_sel, 0);
        chk("R6 idle stall", stall, 0);

        // Directed corner cases
        @(posedge clk); #1;
        ex_src_a = 3; ex_src_b = 3; exmem_dst = 3; exmem_wen = 1; memwb_dst = 3; memwb_wen = 1;
        @(negedge clk);
        chk("R4 both match A", opa_sel, 2);
        chk("R4 both match B", opb_sel, 2);
        @(posedge clk); #1;
        ex_src_a = 7; ex_src_b = 9; exmem_dst = 7; memwb_dst = 9;
        @(negedge clk);
        chk("R10 split A", opa_sel, 2);
        chk("R10 split B", opb_sel, 1);
        @(posedge clk); #1;
        ex_src_a = 0; ex_src_b = 0; exmem_dst = 0; memwb_dst = 0;
        @(negedge clk);
        chk("R5 reg0 A", opa_sel, 0);
        chk("R5 reg0 B", opb_sel, 0);
        @(posedge clk); #1;
        ex_src_a = 4; exmem_dst = 4; exmem_wen = 0; memwb_wen = 0;
        id_src_b = 4; idex_dst = 4; idex_wen = 0; idex_load = 1;
        @(negedge clk);
        chk("R5 wen low A", opa_sel, 0);
        chk("R5 wen low stall", stall, 0);
        @(posedge clk); #1;
        idex_wen = 1;
        @(negedge clk);
        chk("R6 load-use B", stall, 1);
        chk("R8 hold", ifid_hold, 1);
        chk("R8 bubble", idex_bubble, 1);
        @(posedge clk); #1;
        idex_load = 0; exmem_wen = 1;
        @(negedge clk);
        chk("R7 alu no stall", stall, 0);
        chk("R2 exmem A", opa_sel, 2);
        @(posedge clk); #1;
        idex_load = 1; idex_dst = 0; id_src_a = 0; id_src_b = 0;
        @(negedge clk);
        chk("R5 load to reg0", stall, 0);

        // Pipeline stream: load-use, ALU chain, independent, reg0, disabled write
        prog.push_back(mk(1, 2, 0, 1, 1));
        prog.push_back(mk(4, 1, 5, 1, 0));
        prog.push_back(mk(6, 4, 7, 1, 0));
        prog.push_back(mk(8, 9, 10, 1, 0));
        prog.push_back(mk(0, 6, 8, 1, 1));
        prog.push_back(mk(11, 0, 0, 1, 0));
        prog.push_back(mk(12, 3, 3, 0, 1));
        prog.push_back(mk(13, 12, 12, 1, 0));
        prog.push_back(mk(14, 13, 2, 1, 1));
        prog.push_back(mk(15, 2, 14, 1, 0));
        prog.push_back(mk(16, 14, 15, 1, 0));
        run_program();

        // Random streams, small register range for dense hazards
        nstall = 0;
        for (int n = 0; n < 3000; n++)
            prog.push_back(mk($urandom_range(3), $urandom_range(3), $urandom_range(3),
                              1'($urandom_range(1)), 1'($urandom_range(1))));
        run_program();

        // Random raw stage contents
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            ex_src_a = 5'($urandom_range(3)); ex_src_b = 5'($urandom_range(3));
            id_src_a = 5'($urandom_range(3)); id_src_b = 5'($urandom_range(3));
            idex_dst = 5'($urandom_range(3)); idex_wen = 1'($urandom_range(1));
            idex_load = 1'($urandom_range(1));
            exmem_dst = 5'($urandom_range(3)); exmem_wen = 1'($urandom_range(1));
            memwb_dst = 5'($urandom_range(3)); memwb_wen = 1'($urandom_range(1));
            @(negedge clk);
            compare_all();
            if (stall) nstall++;
        end
        chk("R6 stalls seen", int'(nstall > 0), 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule